// File: doc/BRIEF.md
# Four-Channel Convolution Processing Array

This block is the arithmetic heart of a small CNN inference engine. It holds four processing elements, one per output channel. Each element keeps that channel's three filter taps in local registers. A single stream of input pixels, three per beat, is broadcast to all four elements at once, so no weights move while a pass is running. In every valid beat each element multiplies the three pixels by its own taps and adds the products together. It then either starts a new sum or adds onto its running partial sum, as an external sequencer chooses.

Each element keeps a signed 16-bit result that saturates at the signed limits. That result passes through a rectifier and a right-shift requantizer. The output is an activation between 0 and 127 per channel, carried in an 8-bit field. All four channels move in lockstep through a three-register pipeline and present their results under one shared valid flag.

Top module: `conv_pe_array`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `out_act` is 0. All stored taps and partial sums are also 0.
- R2: `out_valid` equals `pix_valid` delayed by exactly three clock cycles, and all four channels present their results together.
- R3: When `wt_we` is high, `wt_data` is written into the taps of the element selected by `wt_ch` (0 to 3). Tap k is held in bits [8k+7:8k], and every tap is a signed 8-bit value. The new taps first apply to pixels sampled on the following cycle. The other elements keep their taps.
- R4: For each valid beat, element c computes p0·w0 + p1·w1 + p2·w2, where pixel k is in `pix_data` bits [8k+7:8k] and is signed 8-bit. If `acc_en` is 1, the element adds its previous result to this sum; if it is 0, it adds zero.
- R5: An element's result changes only on valid beats. It saturates to 32767 or -32768 when the exact sum leaves the signed 16-bit range.
- R6: A result of zero or less produces an activation of 0.
- R7: A positive result is shifted right by `shift_amt`, which is sampled together with the pixels; values above 8 act as 8. The shifted value is then clamped to at most 127. The activation of channel c appears in `out_act` bits [8c+7:8c].
- R8: While `out_valid` is 0, `out_act` holds the last activations that were produced.
- R9: A new pixel beat is accepted on every cycle, and back-to-back accumulating beats each build on the result of the beat before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel beat present |
| pix_data | input | 24 | Three signed 8-bit pixels, broadcast to all elements |
| acc_en | input | 1 | 1 adds to the running partial sum, 0 starts a new sum |
| shift_amt | input | 4 | Requantization right shift for this beat |
| wt_we | input | 1 | Tap write enable |
| wt_ch | input | 2 | Element selected for a tap write |
| wt_data | input | 24 | Three signed 8-bit taps |
| out_valid | output | 1 | Activations valid |
| out_act | output | 32 | Four 8-bit activations, channel c in bits [8c+7:8c] |

## Verification
The bench builds the array with its default parameters: four channels, 8-bit operands, three taps, a 16-bit sum and a 4-bit shift field. With full-scale operands a single beat already exceeds the 16-bit range, so saturation at both limits is easy to reach. The 4-bit shift field can carry values from 9 to 15, which exercises the cap at 8. Tap writes that land in the same cycle as a pixel beat, and idle gaps inside accumulation runs, test the ordering and hold rules.

// File: rtl/conv_pe_pkg.sv
package conv_pe_pkg;
    localparam int unsigned DEF_CH   = 4;
    localparam int unsigned DEF_DW   = 8;
    localparam int unsigned DEF_TAPS = 3;
    localparam int unsigned DEF_AW   = 16;
    localparam int unsigned DEF_SW   = 4;
    localparam int unsigned DEF_OW   = 8;
    localparam int unsigned DEF_MAXSH = 8;

    typedef enum logic {
        MODE_FRESH = 1'b0,
        MODE_ACCUM = 1'b1
    } sum_mode_e;
endpackage

// File: rtl/conv_pe.sv
module conv_pe
    import conv_pe_pkg::*;
#(
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned TAPS = DEF_TAPS,
    parameter int unsigned AW   = DEF_AW,
    parameter int unsigned SW   = DEF_SW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_we,
    input  logic [TAPS*DW-1:0]   wt_data,
    input  logic                 in_valid,
    input  logic [TAPS*DW-1:0]   in_pix,
    input  logic                 in_acc,
    input  logic [SW-1:0]        in_shift,
    output logic                 out_valid,
    output logic [AW-1:0]        out_sum,
    output logic [SW-1:0]        out_shift
);
    localparam int unsigned PW   = 2 * DW;
    localparam int unsigned SUMW = AW + $clog2(TAPS + 1) + 1;
    localparam logic signed [SUMW-1:0] SMAX = {{(SUMW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [SUMW-1:0] SMIN = {{(SUMW-AW+1){1'b1}}, {(AW-1){1'b0}}};

    typedef struct packed {
        logic [TAPS-1:0][DW-1:0] w;
        logic [TAPS-1:0][PW-1:0] prod;
        logic                    v1;
        sum_mode_e               mode1;
        logic [SW-1:0]           sh1;
        logic [AW-1:0]           psum;
        logic                    v2;
        logic [SW-1:0]           sh2;
    } pe_state_t;

    pe_state_t st_d, st_q;

    always_comb begin
        logic signed [SUMW-1:0] total;
        logic signed [PW-1:0]   wx;
        logic signed [PW-1:0]   px;
        st_d  = st_q;
        total = '0;
        wx    = '0;
        px    = '0;
        if (wt_we) begin
            for (int k = 0; k < TAPS; k++) st_d.w[k] = wt_data[k*DW +: DW];
        end
        // stage 1: three multipliers against the local taps
        st_d.v1 = in_valid;
        if (in_valid) begin
            for (int k = 0; k < TAPS; k++) begin
                wx = {{(PW-DW){st_q.w[k][DW-1]}}, st_q.w[k]};
                px = {{(PW-DW){in_pix[k*DW+DW-1]}}, in_pix[k*DW +: DW]};
                st_d.prod[k] = wx * px;
            end
            st_d.mode1 = in_acc ? MODE_ACCUM : MODE_FRESH;
            st_d.sh1   = in_shift;
        end
        // stage 2: mux (zero or partial sum) into the adder, then saturate
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            total = (st_q.mode1 == MODE_ACCUM) ?
                    {{(SUMW-AW){st_q.psum[AW-1]}}, st_q.psum} : '0;
            for (int k = 0; k < TAPS; k++)
                total = total + {{(SUMW-PW){st_q.prod[k][PW-1]}}, st_q.prod[k]};
            if (total > SMAX)      st_d.psum = SMAX[AW-1:0];
            else if (total < SMIN) st_d.psum = SMIN[AW-1:0];
            else                   st_d.psum = total[AW-1:0];
            st_d.sh2 = st_q.sh1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign out_sum   = st_q.psum;
    assign out_shift = st_q.sh2;

    // R3: taps change only on a write
    a_r3_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wt_we |=> $stable(st_q.w));
    // R5: partial sum moves only on a valid product beat
    a_r5_psum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.v1 |=> $stable(st_q.psum));
    // R4: a fresh sum of zero products is zero
    a_r4_fresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.v1 && st_q.mode1 == MODE_FRESH && st_q.prod == '0) |=> (st_q.psum == '0));
endmodule

// File: rtl/relu_quant.sv
module relu_quant
    import conv_pe_pkg::*;
#(
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned SW    = DEF_SW,
    parameter int unsigned OW    = DEF_OW,
    parameter int unsigned MAXSH = DEF_MAXSH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_sum,
    input  logic [SW-1:0] in_shift,
    output logic          out_valid,
    output logic [OW-1:0] out_act
);
    localparam logic [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
    localparam logic [AW-1:0] OMAX_W = {{(AW-OW){1'b0}}, OMAX};

    typedef struct packed {
        logic          v;
        logic [OW-1:0] act;
    } rq_state_t;

    rq_state_t rq_d, rq_q;

    always_comb begin
        logic [AW-1:0] rect;
        logic [SW-1:0] sh_eff;
        logic [AW-1:0] shifted;
        rq_d    = rq_q;
        rq_d.v  = in_valid;
        rect    = ($signed(in_sum) > 0) ? in_sum : '0;
        sh_eff  = (in_shift > SW'(MAXSH)) ? SW'(MAXSH) : in_shift;
        shifted = rect >> sh_eff;
        if (in_valid) begin
            rq_d.act = (shifted > OMAX_W) ? OMAX : shifted[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign out_valid = rq_q.v;
    assign out_act   = rq_q.act;

    // R6: a nonzero activation only comes from a positive sum
    a_r6_relu_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q.v && rq_q.act != '0) |-> ($signed($past(in_sum)) > 0));
    // R7: activation never exceeds the clamp
    a_r7_act_range: assert property (@(posedge clk) disable iff (!rst_n)
        rq_q.v |-> (rq_q.act <= OMAX));
    // R8: no valid input, activation held
    a_r8_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(rq_q.act));
endmodule

// File: rtl/conv_pe_array.sv
module conv_pe_array
    import conv_pe_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CH,
    parameter int unsigned DW     = DEF_DW,
    parameter int unsigned TAPS   = DEF_TAPS,
    parameter int unsigned AW     = DEF_AW,
    parameter int unsigned SW     = DEF_SW,
    parameter int unsigned OW     = DEF_OW,
    parameter int unsigned MAXSH  = DEF_MAXSH,
    localparam int unsigned CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic [TAPS*DW-1:0]   pix_data,
    input  logic                 acc_en,
    input  logic [SW-1:0]        shift_amt,
    input  logic                 wt_we,
    input  logic [CHW-1:0]       wt_ch,
    input  logic [TAPS*DW-1:0]   wt_data,
    output logic                 out_valid,
    output logic [NUM_CH*OW-1:0] out_act
);
    logic [NUM_CH-1:0]         sum_valid;
    logic [NUM_CH-1:0][AW-1:0] sum_val;
    logic [NUM_CH-1:0][SW-1:0] sum_shift;
    logic [NUM_CH-1:0]         ch_valid;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        conv_pe #(.DW(DW), .TAPS(TAPS), .AW(AW), .SW(SW)) pe_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wt_we     (wt_we && (wt_ch == CHW'(c))),
            .wt_data   (wt_data),
            .in_valid  (pix_valid),
            .in_pix    (pix_data),
            .in_acc    (acc_en),
            .in_shift  (shift_amt),
            .out_valid (sum_valid[c]),
            .out_sum   (sum_val[c]),
            .out_shift (sum_shift[c])
        );
        relu_quant #(.AW(AW), .SW(SW), .OW(OW), .MAXSH(MAXSH)) rq_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (sum_valid[c]),
            .in_sum    (sum_val[c]),
            .in_shift  (sum_shift[c]),
            .out_valid (ch_valid[c]),
            .out_act   (out_act[c*OW +: OW])
        );
    end

    assign out_valid = ch_valid[0];

    // R2: fixed three-cycle latency
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid, 3));
    // R2: channels in lockstep
    a_r2_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid == '0) || (ch_valid == '1));
    // R1: quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_act == '0));
endmodule

// File: tb/conv_pe_array_tb_top.sv
`timescale 1ns/1ps
module conv_pe_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        acc_en = 1'b0;
    logic [3:0]  shift_amt = '0;
    logic        wt_we = 1'b0;
    logic [1:0]  wt_ch = '0;
    logic [23:0] wt_data = '0;
    logic        out_valid;
    logic [31:0] out_act;

    int n_tests = 0;
    int n_fail  = 0;

    int mw [4][3];
    int mpsum [4];
    int last_act [4];
    bit hv [3];
    int ha [3][4];
    string ht [3];

    always #2 clk = ~clk;

    conv_pe_array dut_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .acc_en(acc_en), .shift_amt(shift_amt), .wt_we(wt_we), .wt_ch(wt_ch),
        .wt_data(wt_data), .out_valid(out_valid), .out_act(out_act)
    );

    function automatic int sat16(int s);
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic int quant(int ps, int sh);
        int r = (ps > 0) ? ps : 0;
        int s = (sh > 8) ? 8 : sh;
        r = r >> s;
        return (r > 127) ? 127 : r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int p0, int p1, int p2, bit acc, int sh,
                        bit we, int ch, int w0, int w1, int w2, string tag);
        int p [3];
        int w [3];
        p = '{p0, p1, p2};
        w = '{w0, w1, w2};
        // compare outputs for the beat driven three cycles ago
        check({ht[2], " valid"}, int'(out_valid), int'(hv[2]));
        for (int c = 0; c < 4; c++)
            check({ht[2], " act"}, int'(out_act[8*c +: 8]), ha[2][c]);
        hv[2] = hv[1]; ha[2] = ha[1]; ht[2] = ht[1];
        hv[1] = hv[0]; ha[1] = ha[0]; ht[1] = ht[0];
        if (v) begin
            for (int c = 0; c < 4; c++) begin
                int s = acc ? mpsum[c] : 0;
                for (int k = 0; k < 3; k++) s += mw[c][k] * p[k];
                mpsum[c] = sat16(s);
                last_act[c] = quant(mpsum[c], sh);
            end
        end
        hv[0] = v; ha[0] = last_act; ht[0] = tag;
        if (we) for (int k = 0; k < 3; k++) mw[ch][k] = w[k];
        pix_valid = v;
        pix_data  = {8'(p2), 8'(p1), 8'(p0)};
        acc_en    = acc;
        shift_amt = 4'(sh);
        wt_we     = we;
        wt_ch     = 2'(ch);
        wt_data   = {8'(w2), 8'(w1), 8'(w0)};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wload(int ch, int w0, int w1, int w2);
        step(0, 0, 0, 0, 0, 0, 1, ch, w0, w1, w2, "R3");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < 4; c++) begin
            mpsum[c] = 0; last_act[c] = 0;
            for (int k = 0; k < 3; k++) mw[c][k] = 0;
        end
        for (int i = 0; i < 3; i++) begin
            hv[i] = 0; ht[i] = "R1"; ha[i] = '{0, 0, 0, 0};
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 act", int'(out_act), 0);
        idle(3, "R1");

        // R3 distinct taps per channel
        wload(0, 1, 2, 3);
        wload(1, -1, -2, -3);
        wload(2, 127, 127, 127);
        wload(3, -128, 5, 0);
        // R4 fresh sum, R6 negative, R7 clamp
        step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R9 back-to-back accumulate
        step(1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 3, 1, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
        idle(2, "R8");
        step(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
        // R5 saturation both ways
        for (int i = 0; i < 4; i++)
            step(1, 127, 127, 127, 1, 8, 0, 0, 0, 0, 0, "R5");
        step(1, 127, 127, 127, 1, 7, 0, 0, 0, 0, 0, "R7");
        // R7 shift above 8
        step(1, 127, 127, 127, 1, 15, 0, 0, 0, 0, 0, "R7");
        step(1, 100, 50, 20, 0, 12, 0, 0, 0, 0, 0, "R7");
        step(1, -128, -128, -128, 0, 9, 0, 0, 0, 0, 0, "R6");
        // R3 write in same cycle as pixel: old taps apply
        step(1, 10, 10, 10, 0, 0, 1, 0, 4, 4, 4, "R3");
        step(1, 10, 10, 10, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(3, "R8");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit v   = ($urandom % 10) < 8;
            bit we  = ($urandom % 10) == 0;
            string t = we ? "R3" : (v ? "R9" : "R8");
            step(v, int'($urandom % 256) - 128, int'($urandom % 256) - 128,
                 int'($urandom % 256) - 128, bit'($urandom % 2), int'($urandom % 16),
                 we, int'($urandom % 4), int'($urandom % 256) - 128,
                 int'($urandom % 256) - 128, int'($urandom % 256) - 128, t);
        end
        idle(4, "R2");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule